// File: doc/BRIEF.md
# Dual-Channel Switch Command Controller

This block is the digital control core of a two-channel solid-state switch. Each channel drives three enables: a matched A/B pair and a separate C switch. Two select bits per channel choose one of four switch states. Each channel has a hold input that either lets the select bits through or freezes the last selection. The freeze is per channel, so software can update one channel while the other keeps its setting.

Two conditions override the channels. The first is a thermal-trip flag, shared by both channels, that opens every switch while it is active. The second is a supply monitor that reports two comparator levels, an upper one and a lower one. Together they form a lock-out with hysteresis. While lock-out is active, the block blanks all six enables, ignores the select bits and clears the held selections.

After lock-out ends, a channel stays open until its own hold input has been seen low at a clock edge. From that point it follows its select bits again. When a thermal trip clears and the supply is still good, each channel returns to its held state without any new command. Both flags pass through synchronizers, and every enable comes from a flip-flop.

Top module: `dual_switch_ctrl`

## Requirements
- R1: A channel's select field {bit1,bit0} decodes as follows: 00 opens all three switches, 01 closes A and B, 10 closes C, and 11 closes A, B and C.
- R2: The A and B enables of a channel are equal on every cycle.
- R3: When a channel's hold bit is 0, the channel follows its select field. When the hold bit is 1, the channel uses the select field sampled at the last clock edge at which the hold bit was 0.
- R4: While the synchronized thermal flag is 1, all enables of both channels are 0, whichever channel is selected.
- R5: While lock-out is active, all six enables are 0 whatever the hold and select inputs do, and the held selections are cleared to 00.
- R6: After reset or lock-out, a channel's enables stay 0 until a clock edge at which that channel's hold bit is 0. Each channel recovers on its own.
- R7: Lock-out becomes active when the synchronized lower-level flag is 0. It becomes inactive only when the synchronized upper-level flag is 1 and the lower-level flag is 1. The upper-level flag dropping alone does not start lock-out.
- R8: When the thermal flag clears with no lock-out, each recovered channel goes back to its held selection without its hold bit going low.
- R9: During reset all enables are 0 and lock-out is active.
- R10: A change on hold or select appears on the enables after one clock edge. A thermal-flag change appears after SYNC_STAGES+1 edges. A supply-flag change appears after SYNC_STAGES+2 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_i | input | N_CH | Per-channel hold: 0 transparent, 1 frozen |
| sel_i | input | 2*N_CH | Select fields, channel k in bits [2k+1:2k] |
| hot_i | input | 1 | Shared thermal-trip flag, asynchronous |
| vdd_hi_i | input | 1 | Supply above upper comparator level, asynchronous |
| vdd_lo_i | input | 1 | Supply above lower comparator level, asynchronous |
| sw_a_o | output | N_CH | A enables, one per channel |
| sw_b_o | output | N_CH | B enables, one per channel |
| sw_c_o | output | N_CH | C enables, one per channel |

## Verification
The bench builds the block with its default values: two channels and two synchronizer stages. Two channels are enough to show that holding or recovering one channel leaves the other alone, while the shared thermal flag still opens both. With two stages, the latencies of the thermal and supply paths are short fixed counts, so the bench checks the exact edge at which the enables drop, not just that they drop eventually.

// File: rtl/dual_switch_ctrl.sv
module dual_switch_ctrl #(
  parameter int N_CH        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   hold_i,
  input  logic [2*N_CH-1:0] sel_i,
  input  logic              hot_i,
  input  logic              vdd_hi_i,
  input  logic              vdd_lo_i,
  output logic [N_CH-1:0]   sw_a_o,
  output logic [N_CH-1:0]   sw_b_o,
  output logic [N_CH-1:0]   sw_c_o
);
  localparam int SW = 2;

  logic [SYNC_STAGES-1:0] hot_sync, hi_sync, lo_sync;
  logic hot_s, hi_s, lo_s, lockout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_sync <= '0;
      hi_sync  <= '0;
      lo_sync  <= '0;
    end else begin
      hot_sync <= {hot_sync[SYNC_STAGES-2:0], hot_i};
      hi_sync  <= {hi_sync[SYNC_STAGES-2:0], vdd_hi_i};
      lo_sync  <= {lo_sync[SYNC_STAGES-2:0], vdd_lo_i};
    end
  end

  assign hot_s = hot_sync[SYNC_STAGES-1];
  assign hi_s  = hi_sync[SYNC_STAGES-1];
  assign lo_s  = lo_sync[SYNC_STAGES-1];

  // hysteresis: lower level trips, upper level releases
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lockout_q <= 1'b1;
    else if (!lo_s) lockout_q <= 1'b1;
    else if (hi_s)  lockout_q <= 1'b0;
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [SW-1:0] held_q, eff;
    logic rec_q, go, a_q, b_q, c_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held_q <= '0;
        rec_q  <= 1'b0;
      end else if (lockout_q) begin
        held_q <= '0;
        rec_q  <= 1'b0;
      end else if (!hold_i[ch]) begin
        held_q <= sel_i[SW*ch +: SW];
        rec_q  <= 1'b1;
      end
    end

    assign eff = hold_i[ch] ? held_q : sel_i[SW*ch +: SW];
    assign go  = !lockout_q && !hot_s && (rec_q || !hold_i[ch]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= 1'b0;
        b_q <= 1'b0;
        c_q <= 1'b0;
      end else begin
        a_q <= go && eff[0];
        b_q <= go && eff[0];
        c_q <= go && eff[1];
      end
    end

    assign sw_a_o[ch] = a_q;
    assign sw_b_o[ch] = b_q;
    assign sw_c_o[ch] = c_q;

    assert_wait_reopen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rec_q && hold_i[ch]) |=> (!sw_a_o[ch] && !sw_b_o[ch] && !sw_c_o[ch]));
  end

  assert_hot_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hot_s |=> (sw_a_o == '0 && sw_b_o == '0 && sw_c_o == '0));

  assert_lock_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lockout_q |=> (sw_a_o == '0 && sw_b_o == '0 && sw_c_o == '0));

  assert_lock_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout_q && !hi_s) |=> lockout_q);

  assert_lock_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lockout_q && lo_s) |=> !lockout_q);
endmodule

// File: tb/dual_switch_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_switch_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] hold_i = 2'b11;
  logic [3:0] sel_i = 4'b0000;
  logic       hot_i = 1'b0, vdd_hi_i = 1'b0, vdd_lo_i = 1'b0;
  logic [1:0] sw_a_o, sw_b_o, sw_c_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  dual_switch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .sel_i(sel_i), .hot_i(hot_i),
    .vdd_hi_i(vdd_hi_i), .vdd_lo_i(vdd_lo_i),
    .sw_a_o(sw_a_o), .sw_b_o(sw_b_o), .sw_c_o(sw_c_o));

  // [9:8] hold {ch1,ch0}, [7:4] sel {ch1,ch0}, [3:2] A/B expected, [1:0] C expected
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    {2'b00, 4'b0000, 2'b00, 2'b00},
    {2'b00, 4'b0001, 2'b01, 2'b00},
    {2'b00, 4'b0010, 2'b00, 2'b01},
    {2'b00, 4'b0011, 2'b01, 2'b01},
    {2'b00, 4'b0100, 2'b10, 2'b00},
    {2'b00, 4'b1011, 2'b01, 2'b11},
    {2'b01, 4'b1100, 2'b11, 2'b11},
    {2'b11, 4'b0000, 2'b11, 2'b11},
    {2'b10, 4'b0001, 2'b11, 2'b10},
    {2'b00, 4'b0110, 2'b10, 2'b01},
    {2'b10, 4'b0000, 2'b10, 2'b00},
    {2'b00, 4'b0000, 2'b00, 2'b00}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] ab, input logic [1:0] c);
    checks++;
    if (sw_a_o !== ab || sw_b_o !== ab || sw_c_o !== c) begin
      fails++;
      $display("FAIL %s: got a=%b b=%b c=%b expected a=%b b=%b c=%b",
               req, sw_a_o, sw_b_o, sw_c_o, ab, ab, c);
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    step(2);
    chk("R9 reset", 2'b00, 2'b00);
    rst_n = 1'b1;
    vdd_lo_i = 1'b1; vdd_hi_i = 1'b1; sel_i = 4'b1111;
    step(6);
    chk("R6 no reopen after power-up", 2'b00, 2'b00);
    hold_i = 2'b00; sel_i = 4'b0101;
    step(1);
    chk("R6 R10 reopened", 2'b11, 2'b00);

    for (int i = 0; i < NV; i++) begin
      hold_i = VEC[i][9:8];
      sel_i  = VEC[i][7:4];
      step(1);
      chk($sformatf("R1 R2 R3 row %0d", i), VEC[i][3:2], VEC[i][1:0]);
    end

    hold_i = 2'b00; sel_i = 4'b1111;
    step(1);
    chk("R1 all on", 2'b11, 2'b11);
    hot_i = 1'b1;
    step(2);
    chk("R10 thermal not yet", 2'b11, 2'b11);
    step(1);
    chk("R10 R4 thermal off", 2'b00, 2'b00);
    sel_i = 4'b0110;
    step(1);
    chk("R4 select ignored while hot", 2'b00, 2'b00);
    hold_i = 2'b11; sel_i = 4'b0000;
    step(2);
    chk("R4 still off", 2'b00, 2'b00);
    hot_i = 1'b0;
    step(4);
    chk("R8 resume held state", 2'b10, 2'b01);

    hold_i = 2'b00; sel_i = 4'b1111;
    step(1);
    chk("R1 all on again", 2'b11, 2'b11);
    vdd_lo_i = 1'b0; vdd_hi_i = 1'b0;
    step(3);
    chk("R10 lockout not yet", 2'b11, 2'b11);
    step(1);
    chk("R10 R5 lockout off", 2'b00, 2'b00);
    sel_i = 4'b0101;
    step(2);
    chk("R5 inputs ignored", 2'b00, 2'b00);
    vdd_lo_i = 1'b1;
    step(6);
    chk("R7 no release below upper level", 2'b00, 2'b00);
    hold_i = 2'b11; sel_i = 4'b1111;
    vdd_hi_i = 1'b1;
    step(6);
    chk("R6 R5 released but held and cleared", 2'b00, 2'b00);
    hold_i = 2'b10; sel_i = 4'b0111;
    step(1);
    chk("R6 only channel 0 recovers", 2'b01, 2'b01);
    hold_i = 2'b00;
    step(1);
    chk("R6 channel 1 recovers", 2'b11, 2'b01);
    vdd_hi_i = 1'b0;
    step(6);
    chk("R7 upper drop alone keeps running", 2'b11, 2'b01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule